// File: doc/BRIEF.md
# Error Injection Countdown and Signal Request Unit

This unit sits beside the status register of one error record. It has two jobs. The first is a software-armed down-counter that creates a synthetic error. Software loads a 16-bit count. The counter moves down by one on every tick of a rate-enable input. When it lands on zero, the unit pulses a strobe that tells the status register to set its valid bit. Loading zero leaves the counter idle. Errors that hardware detects and logs do not affect the countdown.

The second job is signal generation. The unit watches the valid bit of the status register. On every change of valid from 0 to 1, whatever caused it, the unit issues one request pulse on one of three lines: low-priority interrupt, high-priority interrupt or platform-specific signal. The line is chosen by a 2-bit enable that belongs to the most severe class bit set in the status. Critical ranks above deferred, and deferred ranks above corrected. A record that has valid set but no class bit set is an informational update and uses the corrected-class enable. A global reporting enable gates every request. Enables for classes the instance does not support are stuck at zero.

Top module: `err_inject_signaler`

## Requirements
- R1: After reset the count is 0, the strobe is low, all three request lines are low and the enable readback `en_rdata` is 0.
- R2: A pulse on `inj_wr` loads `inj_wdata` into the count, which is visible in the next cycle. A loaded value of 0 never produces a strobe.
- R3: In each cycle where `tick` is high, `inj_wr` is low and the count is nonzero, the count drops by exactly 1. At 0 the count holds until the next load. When a load and a tick fall in the same cycle, the load wins.
- R4: `inj_set_valid` is high for exactly one cycle: the first cycle in which a tick has brought the count from 1 to 0.
- R5: Activity on `st_valid` and `st_class` changes neither the count sequence nor the strobe timing.
- R6: One cycle after `st_valid` is sampled changing from 0 to 1, exactly one request line pulses for one cycle. The selected enable value maps as follows: 1 pulses `sig_low`, 2 pulses `sig_high`, 3 pulses `sig_plat`, and 0 pulses nothing.
- R7: The enable is taken from the most severe class bit set in `st_class`. Bit 2 is critical, bit 1 is deferred and bit 0 is corrected, and critical ranks highest. When no class bit is set, the corrected enable (`en_rdata[1:0]`) is used.
- R8: No request line pulses when `rpt_en` was low at the clock edge where the valid rise was sampled.
- R9: While `st_valid` stays high, and when it falls, no request is issued.
- R10: The enable fields are packed into `en_wdata` and `en_rdata` as corrected [1:0], deferred [3:2] and critical [5:4]. A field for a class that is not in `CLASS_SUPPORT` reads back 0 whatever is written, and that class then produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inj_wr | input | 1 | Load strobe for the injection count |
| inj_wdata | input | CNT_W | Count value to load |
| tick | input | 1 | Countdown rate enable |
| rpt_en | input | 1 | Global reporting enable |
| en_wr | input | 1 | Write strobe for the class enables |
| en_wdata | input | 6 | Class enables to write: corrected [1:0], deferred [3:2], critical [5:4] |
| st_valid | input | 1 | Valid bit of the status register |
| st_class | input | 3 | Class bits of the status register: corrected [0], deferred [1], critical [2] |
| inj_count | output | CNT_W | Current injection count |
| inj_set_valid | output | 1 | One-cycle request to set status valid |
| en_rdata | output | 6 | Class enables as stored, with unsupported fields reading 0 |
| sig_low | output | 1 | Low-priority interrupt request pulse |
| sig_high | output | 1 | High-priority interrupt request pulse |
| sig_plat | output | 1 | Platform-specific signal request pulse |

## Verification
The two functions that can meet in a single cycle are the expiry of the countdown and a hardware-logged error that sets valid. The bench arms a short countdown. At the moment the strobe is seen, it raises the hardware valid line, so valid rises from both sources within the same clock. The scoreboard then expects exactly one request, and any second pulse counts as unexpected. In a separate case the bench sets and clears hardware valid partway through a long countdown. It then checks that the count follows the plain sequence one value per tick and that the strobe lands on the originally computed cycle.

// File: rtl/eis_pkg.sv
package eis_pkg;

   localparam int unsigned NUM_CLASS = 3;
   localparam int unsigned EN_W      = 2;

   localparam int unsigned CLS_CORR  = 0;
   localparam int unsigned CLS_DEFER = 1;
   localparam int unsigned CLS_CRIT  = 2;

   typedef enum logic [EN_W-1:0] {
      SIG_OFF  = 2'd0,
      SIG_LOW  = 2'd1,
      SIG_HIGH = 2'd2,
      SIG_PLAT = 2'd3
   } sig_kind_e;

endpackage

// File: rtl/eis_countdown.sv
module eis_countdown #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic [CNT_W-1:0] count,
   output logic             expire
);

   localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
   localparam logic [CNT_W-1:0] CNT_ZERO = '0;

   logic running;
   assign running = (count != CNT_ZERO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count  <= CNT_ZERO;
         expire <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (load) begin
            count <= load_val;
         end else if (tick && running) begin
            count <= count - CNT_ONE;
            if (count == CNT_ONE) begin
               expire <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/eis_enable_regs.sv
module eis_enable_regs
   import eis_pkg::*;
#(
   parameter logic [NUM_CLASS-1:0] CLASS_SUPPORT = 3'b111
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr,
   input  logic [NUM_CLASS*EN_W-1:0]     wdata,
   output logic [NUM_CLASS*EN_W-1:0]     en
);

   localparam int unsigned FLAT_W = NUM_CLASS * EN_W;

   logic [FLAT_W-1:0] keep_mask;
   logic [FLAT_W-1:0] en_q;

   for (genvar g = 0; g < NUM_CLASS; g++) begin : g_mask
      if (CLASS_SUPPORT[g]) begin : g_on
         assign keep_mask[g*EN_W +: EN_W] = {EN_W{1'b1}};
      end else begin : g_off
         assign keep_mask[g*EN_W +: EN_W] = {EN_W{1'b0}};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (wr) begin
         en_q <= wdata & keep_mask;
      end
   end

   assign en = en_q;

endmodule

// File: rtl/eis_sig_select.sv
module eis_sig_select
   import eis_pkg::*;
(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      glob_en,
   input  logic                      st_valid,
   input  logic [NUM_CLASS-1:0]      st_class,
   input  logic [NUM_CLASS*EN_W-1:0] en,
   output logic                      sig_low,
   output logic                      sig_high,
   output logic                      sig_plat
);

   logic            valid_q;
   logic            rise;
   logic [EN_W-1:0] sel_en;
   sig_kind_e       kind;

   assign rise = st_valid & ~valid_q;

   always_comb begin
      if (st_class[CLS_CRIT]) begin
         sel_en = en[CLS_CRIT*EN_W +: EN_W];
      end else if (st_class[CLS_DEFER]) begin
         sel_en = en[CLS_DEFER*EN_W +: EN_W];
      end else begin
         sel_en = en[CLS_CORR*EN_W +: EN_W];
      end
   end

   assign kind = sig_kind_e'(sel_en);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q  <= 1'b0;
         sig_low  <= 1'b0;
         sig_high <= 1'b0;
         sig_plat <= 1'b0;
      end else begin
         valid_q  <= st_valid;
         sig_low  <= rise && glob_en && (kind == SIG_LOW);
         sig_high <= rise && glob_en && (kind == SIG_HIGH);
         sig_plat <= rise && glob_en && (kind == SIG_PLAT);
      end
   end

endmodule

// File: rtl/err_inject_signaler.sv
module err_inject_signaler
   import eis_pkg::*;
#(
   parameter int unsigned          CNT_W         = 16,
   parameter logic [NUM_CLASS-1:0] CLASS_SUPPORT = 3'b111
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      inj_wr,
   input  logic [CNT_W-1:0]          inj_wdata,
   input  logic                      tick,
   input  logic                      rpt_en,
   input  logic                      en_wr,
   input  logic [NUM_CLASS*EN_W-1:0] en_wdata,
   input  logic                      st_valid,
   input  logic [NUM_CLASS-1:0]      st_class,
   output logic [CNT_W-1:0]          inj_count,
   output logic                      inj_set_valid,
   output logic [NUM_CLASS*EN_W-1:0] en_rdata,
   output logic                      sig_low,
   output logic                      sig_high,
   output logic                      sig_plat
);

   if (CNT_W < 2) begin : g_bad_width
      $error("err_inject_signaler: CNT_W must be at least 2");
   end

   eis_countdown #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (inj_wr),
      .load_val (inj_wdata),
      .tick     (tick),
      .count    (inj_count),
      .expire   (inj_set_valid)
   );

   eis_enable_regs #(
      .CLASS_SUPPORT (CLASS_SUPPORT)
   ) u_enables (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (en_wr),
      .wdata (en_wdata),
      .en    (en_rdata)
   );

   eis_sig_select u_select (
      .clk      (clk),
      .rst_n    (rst_n),
      .glob_en  (rpt_en),
      .st_valid (st_valid),
      .st_class (st_class),
      .en       (en_rdata),
      .sig_low  (sig_low),
      .sig_high (sig_high),
      .sig_plat (sig_plat)
   );

endmodule

// File: rtl/eis_checker.sv
module eis_checker #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             inj_wr,
   input logic [CNT_W-1:0] inj_wdata,
   input logic             tick,
   input logic             rpt_en,
   input logic             st_valid,
   input logic [CNT_W-1:0] inj_count,
   input logic             inj_set_valid,
   input logic             sig_low,
   input logic             sig_high,
   input logic             sig_plat
);

   localparam logic [CNT_W-1:0] C_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic any_sig;
   assign any_sig = sig_low | sig_high | sig_plat;

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(inj_wr) |-> inj_count == $past(inj_wdata));

   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(inj_wr) && $past(tick) && $past(inj_count) != '0)
         |-> inj_count == $past(inj_count) - C_ONE);

   assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(inj_wr) && $past(inj_count) == '0) |-> inj_count == '0);

   assert_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      inj_set_valid |-> (inj_count == '0 && $past(inj_count) == C_ONE && !$past(inj_wr)));

   assert_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sig_low, sig_high, sig_plat}));

   assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      any_sig |-> $past(rpt_en));

   assert_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      any_sig |-> $past(st_valid));

   assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      any_sig |=> !any_sig);

endmodule

bind err_inject_signaler eis_checker #(
   .CNT_W (CNT_W)
) u_eis_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .inj_wr        (inj_wr),
   .inj_wdata     (inj_wdata),
   .tick          (tick),
   .rpt_en        (rpt_en),
   .st_valid      (st_valid),
   .inj_count     (inj_count),
   .inj_set_valid (inj_set_valid),
   .sig_low       (sig_low),
   .sig_high      (sig_high),
   .sig_plat      (sig_plat)
);

// File: tb/tb_err_inject_signaler.sv
`timescale 1ns/1ps
module tb_err_inject_signaler;

   localparam int unsigned CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          inj_wr = 1'b0;
   logic [CW-1:0] inj_wdata = '0;
   logic          tick = 1'b0;
   logic          rpt_en = 1'b0;
   logic          en_wr = 1'b0;
   logic [5:0]    en_wdata = '0;
   logic          st_v_drv = 1'b0;
   logic          st_v_inj;
   logic          clr_inj = 1'b0;
   logic [2:0]    st_class = '0;
   logic          st_valid;
   logic [CW-1:0] inj_count;
   logic          inj_set_valid;
   logic [5:0]    en_rdata;
   logic          sig_low, sig_high, sig_plat;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [1:0] exp_kind[$];
   string      exp_req[$];

   always #4 clk = ~clk;

   assign st_valid = st_v_drv | st_v_inj;

   // status valid model: set by the injection strobe, cleared by the bench
   always @(posedge clk) begin
      if (!rst_n || clr_inj) st_v_inj <= 1'b0;
      else if (inj_set_valid) st_v_inj <= 1'b1;
   end

   err_inject_signaler #(.CNT_W(CW), .CLASS_SUPPORT(3'b101)) dut (
      .clk(clk), .rst_n(rst_n), .inj_wr(inj_wr), .inj_wdata(inj_wdata),
      .tick(tick), .rpt_en(rpt_en), .en_wr(en_wr), .en_wdata(en_wdata),
      .st_valid(st_valid), .st_class(st_class), .inj_count(inj_count),
      .inj_set_valid(inj_set_valid), .en_rdata(en_rdata),
      .sig_low(sig_low), .sig_high(sig_high), .sig_plat(sig_plat));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic push_exp(input logic [1:0] k, input string req);
      exp_kind.push_back(k);
      exp_req.push_back(req);
   endtask

   // monitor: every request pulse is matched against the scoreboard
   always @(negedge clk) begin
      if (rst_n && (sig_low || sig_high || sig_plat)) begin
         logic [1:0] act;
         act = sig_plat ? 2'd3 : (sig_high ? 2'd2 : 2'd1);
         if ($countones({sig_low, sig_high, sig_plat}) != 1)
            check(0, "R6", "request lines not one-hot", int'({sig_plat, sig_high, sig_low}), 1);
         if (exp_kind.size() == 0) begin
            check(0, "R9", "unexpected request", int'(act), 0);
         end else begin
            logic [1:0] e;
            string r;
            e = exp_kind.pop_front();
            r = exp_req.pop_front();
            check(act == e, r, "request kind", int'(act), int'(e));
         end
      end
   end

   task automatic drain(input string req);
      repeat (3) @(negedge clk);
      check(exp_kind.size() == 0, req, "expected request missing", exp_kind.size(), 0);
      exp_kind.delete();
      exp_req.delete();
   endtask

   task automatic hw_error(input logic [2:0] cls);
      @(negedge clk);
      st_class = cls;
      st_v_drv = 1'b1;
      repeat (4) @(negedge clk);
      st_v_drv = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic write_en(input logic [5:0] v);
      @(negedge clk);
      en_wr = 1'b1;
      en_wdata = v;
      @(negedge clk);
      en_wr = 1'b0;
   endtask

   task automatic load(input logic [CW-1:0] v);
      @(negedge clk);
      inj_wr = 1'b1;
      inj_wdata = v;
      @(negedge clk);
      inj_wr = 1'b0;
      check(inj_count == v, "R2", "loaded count", int'(inj_count), int'(v));
   endtask

   task automatic clear_status();
      @(negedge clk);
      clr_inj = 1'b1;
      st_v_drv = 1'b0;
      @(negedge clk);
      clr_inj = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(inj_count == 0, "R1", "count after reset", int'(inj_count), 0);
      check(inj_set_valid == 0, "R1", "strobe after reset", int'(inj_set_valid), 0);
      check(en_rdata == 0, "R1", "enables after reset", int'(en_rdata), 0);
      check({sig_low, sig_high, sig_plat} == 0, "R1", "requests after reset",
            int'({sig_low, sig_high, sig_plat}), 0);

      // R10: deferred class unsupported in this instance
      write_en(6'b10_11_01);
      check(en_rdata == 6'b10_00_01, "R10", "enable readback", int'(en_rdata), int'(6'b10_00_01));
      rpt_en = 1'b1;

      // R6: corrected class -> low request, held valid issues nothing more (R9)
      push_exp(2'd1, "R6");
      hw_error(3'b001);
      drain("R6");

      // R7: critical outranks corrected
      push_exp(2'd2, "R7");
      hw_error(3'b101);
      drain("R7");

      // R7: informational record uses corrected enable
      push_exp(2'd1, "R7");
      hw_error(3'b000);
      drain("R7");

      // R10: deferred enable stuck at 0 -> no request
      hw_error(3'b010);
      drain("R10");

      // R8: global enable off
      rpt_en = 1'b0;
      hw_error(3'b001);
      drain("R8");
      rpt_en = 1'b1;

      // R6: enable value 3 -> platform line
      write_en(6'b10_00_11);
      push_exp(2'd3, "R6");
      hw_error(3'b001);
      drain("R6");
      write_en(6'b10_00_01);

      // R3 / R4: countdown of 5 with critical class in status
      st_class = 3'b100;
      load(16'd5);
      tick = 1'b1;
      push_exp(2'd2, "R4");
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         check(inj_count == CW'(5 - k), "R3", "count step", int'(inj_count), 5 - k);
         check(inj_set_valid == (k == 5), "R4", "strobe timing", int'(inj_set_valid), int'(k == 5));
      end
      @(negedge clk);
      check(inj_count == 0, "R3", "count holds at zero", int'(inj_count), 0);
      check(inj_set_valid == 0, "R4", "strobe one cycle", int'(inj_set_valid), 0);
      drain("R4");
      clear_status();

      // R2: loading zero disables
      load(16'd0);
      repeat (20) @(negedge clk);
      check(inj_count == 0, "R2", "zero load stays idle", int'(inj_count), 0);
      drain("R2");

      // R3: load beats tick in the same cycle
      load(16'd9);
      @(negedge clk);
      inj_wr = 1'b1;
      inj_wdata = 16'd40;
      @(negedge clk);
      inj_wr = 1'b0;
      check(inj_count == 40, "R3", "load wins over tick", int'(inj_count), 40);

      // R5: hardware errors during a countdown leave the counter untouched
      load(16'd12);
      for (int k = 1; k <= 12; k++) begin
         @(negedge clk);
         check(inj_count == CW'(12 - k), "R5", "count during hw activity", int'(inj_count), 12 - k);
         check(inj_set_valid == (k == 12), "R5", "strobe timing", int'(inj_set_valid), int'(k == 12));
         if (k == 3) begin
            st_class = 3'b001;
            st_v_drv = 1'b1;
            push_exp(2'd1, "R5");
         end
         if (k == 6) st_v_drv = 1'b0;
         if (k == 8) begin
            st_class = 3'b100;
            push_exp(2'd2, "R5");
         end
      end
      drain("R5");
      clear_status();

      // coincidence: injection expiry and hardware valid rise together
      st_class = 3'b001;
      load(16'd3);
      push_exp(2'd1, "R6");
      for (int k = 1; k <= 3; k++) begin
         @(negedge clk);
         if (k == 3) begin
            check(inj_set_valid == 1, "R4", "strobe before coincidence", int'(inj_set_valid), 1);
            st_v_drv = 1'b1;
         end
      end
      repeat (4) @(negedge clk);
      drain("R6");
      tick = 1'b0;
      clear_status();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule